// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical address onto one of four SDRAM rows that share a single channel. Each row owns a byte-wide limit register. The limit is counted in 16 MB units, so the row's upper address bound is the register value shifted left by 24 bits. The limits are cumulative. Row 0 begins at address 0, and every later row begins where the row below it ends. A row whose limit equals its predecessor's limit holds no memory. A module of 16 MB to 512 MB fits in any row.

The decoder compares the top address bits against every limit at the same time. It raises the chip-select of the lowest-numbered row whose limit lies above the address. An address at or beyond every limit raises no chip-select and drops the hit flag. The limits are loaded through a simple write port, one row per cycle. The decode itself is combinational on the address and reads the registered limits.

Top module: `rbd_decoder`

## Requirements
- R1: After synchronous reset every limit is 0, so every row is empty and, for any address, `cs` is 4'b0000 and `hit` is 0.
- R2: When `cfg_we` is 1 at a rising clock edge, the limit of the row numbered `cfg_idx` (0 to 3) takes `cfg_data`. The other rows keep their limits.
- R3: With non-decreasing limits L0..L3, row n is selected exactly when (L(n-1) << 24) <= addr < (Ln << 24), where L(-1) is taken as 0.
- R4: `cs` has at most one bit set, and bit n stands for row n. `hit` is 1 exactly when one bit of `cs` is set.
- R5: An address at or above the last limit (addr[31:24] >= L3) that no lower row claims gives `cs` = 0 and `hit` = 0.
- R6: A row whose limit equals the previous row's limit (or equals 0 for row 0) is never selected.
- R7: With limits out of order, the selected row is the lowest-numbered row whose limit exceeds addr[31:24].
- R8: A new limit written at a clock edge takes effect in the decode only after that edge. In the cycle that carries the write, the decode still uses the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Limit write strobe |
| cfg_idx | input | 2 | Row whose limit is written |
| cfg_data | input | 8 | New limit, in 16 MB units |
| addr | input | 32 | Physical address to decode |
| cs | output | 4 | One-hot row select |
| hit | output | 1 | Address falls inside some row |

## Verification
A limit write and a decode can fall in the same cycle. This matters most when the address sits right at the limit being changed. The bench holds the address steady and drives a write that moves that row's limit across the address. It samples the outputs once before the clock edge and expects the old decision, then samples again after the edge and expects the new one. Full sweeps of the top address byte, each with three low-bit patterns, are run under monotone, empty-row and out-of-order limit sets, and each result is compared against an arithmetic model.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int RBD_ROWS       = 4;
  localparam int RBD_ADDR_W     = 32;
  localparam int RBD_UNIT_SHIFT = 24;
endpackage

// File: rtl/rbd_bound_regs.sv
module rbd_bound_regs #(
  parameter int NUM_ROWS = 4,
  parameter int BND_W    = 8,
  parameter int IDX_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [BND_W-1:0]                 data,
  output logic [NUM_ROWS-1:0][BND_W-1:0]   bnd
);
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        bnd[r] <= '0;
      else if (we && idx == IDX_W'(r))
        bnd[r] <= data;
    end
  end
endmodule

// File: rtl/rbd_row_cmp.sv
module rbd_row_cmp #(
  parameter int BND_W = 8
) (
  input  logic [BND_W-1:0] addr_hi,
  input  logic [BND_W-1:0] limit,
  output logic             below
);
  // Limit has zero low bits, so a full compare reduces to the top field.
  assign below = addr_hi < limit;
endmodule

// File: rtl/rbd_prio_sel.sv
module rbd_prio_sel #(
  parameter int NUM_ROWS = 4
) (
  input  logic [NUM_ROWS-1:0] below,
  output logic [NUM_ROWS-1:0] sel,
  output logic                any
);
  // Isolate the lowest set bit: the first row whose limit exceeds the address.
  assign sel = below & ~(below - NUM_ROWS'(1));
  assign any = |below;
endmodule

// File: rtl/rbd_decoder.sv
module rbd_decoder
  import rbd_pkg::*;
#(
  parameter int NUM_ROWS   = RBD_ROWS,
  parameter int ADDR_W     = RBD_ADDR_W,
  parameter int UNIT_SHIFT = RBD_UNIT_SHIFT,
  localparam int BND_W     = ADDR_W - UNIT_SHIFT,
  localparam int IDX_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [BND_W-1:0]    cfg_data,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_ROWS-1:0] cs,
  output logic                hit
);
  logic [NUM_ROWS-1:0][BND_W-1:0] bnd_q;
  logic [NUM_ROWS-1:0]            below;
  logic [BND_W-1:0]               addr_hi;

  assign addr_hi = addr[ADDR_W-1:UNIT_SHIFT];

  rbd_bound_regs #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .data(cfg_data), .bnd(bnd_q)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cmp
    rbd_row_cmp #(.BND_W(BND_W)) u_cmp (
      .addr_hi(addr_hi), .limit(bnd_q[r]), .below(below[r])
    );
  end

  rbd_prio_sel #(.NUM_ROWS(NUM_ROWS)) u_sel (
    .below(below), .sel(cs), .any(hit)
  );
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int NUM_ROWS = 4,
  parameter int ADDR_W   = 32,
  parameter int BND_W    = 8,
  parameter int IDX_W    = 2
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           cfg_we,
  input logic [IDX_W-1:0]               cfg_idx,
  input logic [BND_W-1:0]               cfg_data,
  input logic [ADDR_W-1:0]              addr,
  input logic [NUM_ROWS-1:0]            cs,
  input logic                           hit,
  input logic [NUM_ROWS-1:0][BND_W-1:0] bnd
);
  logic [BND_W-1:0] hi;
  assign hi = addr[ADDR_W-1:ADDR_W-BND_W];

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hit && cs == '0)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we) && !$past(rst)) |-> bnd[$past(cfg_idx)] == $past(cfg_data)); // R2

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs)); // R4

  AST_HIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    hit == ($countones(cs) == 1)); // R4

  AST_MISS_BEYOND: assert property (@(posedge clk) disable iff (rst)
    !hit |-> hi >= bnd[NUM_ROWS-1]); // R5

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    AST_SEL_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
      cs[r] |-> hi < bnd[r]); // R3
    if (r > 0) begin : g_prev
      AST_SEL_FIRST: assert property (@(posedge clk) disable iff (rst)
        cs[r] |-> hi >= bnd[r-1]); // R7
    end
  end
endmodule

bind rbd_decoder rbd_checker #(
  .NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W), .BND_W(BND_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
  .addr(addr), .cs(cs), .hit(hit), .bnd(bnd_q)
);

// File: tb/tb_rbd_decoder.sv
module tb_rbd_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       cfg_we = 0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic [31:0] addr = '0;
  logic [3:0] cs;
  logic       hit;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] lim [4];

  rbd_decoder dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .addr(addr), .cs(cs), .hit(hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] model(input logic [7:0] h);
    for (int n = 0; n < 4; n++)
      if (h < lim[n]) return 4'b0001 << n;
    return 4'b0000;
  endfunction

  task automatic check(input string req, input logic [3:0] exp_cs);
    n_chk++;
    if (cs !== exp_cs || hit !== (exp_cs != 0)) begin
      n_bad++;
      $display("FAIL %s addr=%h cs=%b hit=%b expected cs=%b hit=%b",
               req, addr, cs, hit, exp_cs, exp_cs != 0);
    end
  endtask

  task automatic put(input int row, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(row); cfg_data = v;
    @(negedge clk);
    cfg_we = 0;
    lim[row] = v;
  endtask

  task automatic load(input logic [7:0] a, b, c, d);
    put(0, a); put(1, b); put(2, c); put(3, d);
  endtask

  task automatic sweep(input string req);
    logic [23:0] lows [3] = '{24'h000000, 24'hFFFFFF, 24'h5A3C71};
    for (int h = 0; h < 256; h++) begin
      for (int k = 0; k < 3; k++) begin
        logic [3:0] e;
        addr = {8'(h), lows[k]};
        #1;
        e = model(8'(h));
        check((e == 0) ? "R5" : req, e);
        n_chk++;
        if ($countones(cs) > 1 || hit !== (cs != 0)) begin
          n_bad++;
          $display("FAIL R4 addr=%h cs=%b hit=%b expected onehot0 with hit=|cs",
                   addr, cs, hit);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) lim[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: every row empty after reset
    sweep("R1");

    // R2: write a single row and observe through decode
    put(2, 8'h50);
    addr = 32'h4F00_0000; #1; check("R2", 4'b0100);
    addr = 32'h5000_0000; #1; check("R2", 4'b0000);

    // R3: monotone limits
    load(8'h10, 8'h20, 8'h40, 8'h80);
    sweep("R3");
    addr = 32'h0FFF_FFFF; #1; check("R3", 4'b0001);
    addr = 32'h1000_0000; #1; check("R3", 4'b0010);
    addr = 32'h8000_0000; #1; check("R5", 4'b0000);

    // R6: empty rows (row 1 equals row 0, row 3 equals row 2)
    load(8'h08, 8'h08, 8'h30, 8'h30);
    sweep("R6");
    // R6: row 0 empty at zero
    load(8'h00, 8'h20, 8'h20, 8'hFF);
    sweep("R6");
    addr = 32'h0000_0000; #1; check("R6", 4'b0010);

    // R7: out-of-order limits
    load(8'h40, 8'h20, 8'h80, 8'h60);
    sweep("R7");
    addr = 32'h6000_0000; #1; check("R7", 4'b0100);

    // R8: write and decode in the same cycle
    load(8'h10, 8'h20, 8'h40, 8'h80);
    addr = 32'h3000_0000;
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'd2; cfg_data = 8'h30;
    #2; check("R8", 4'b0100);
    @(posedge clk); #1;
    cfg_we = 0; lim[2] = 8'h30;
    check("R8", 4'b1000);

    // R1: reset clears written limits
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++) lim[i] = 8'h00;
    addr = 32'h0000_0000; #1; check("R1", 4'b0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule